// File: doc/BRIEF.md
# Command Slot Issue Scheduler

This block tracks which command slots of one storage port have been issued by software and hands them, one at a time, to a command engine. Software posts work by writing a mask to the issue register. Each write adds bits to the pending set and never removes any. A small port control register holds a run bit and a receive-enable bit. Each of these has a read-only status copy that follows it. While the run bit is set, the scheduler takes the lowest-numbered pending slot and gives the engine a one-cycle start pulse that carries the slot index. It then waits for the engine to answer.

The engine can answer in two ways. It can finish at once with a done pulse, and the slot's pending bit is then cleared. It can instead go busy, or raise data-request. In that case the slot is recorded as the busy slot and stays pending until both busy and data-request drop. Only then is the bit cleared and the record dropped. A port reset drops the busy record and returns the scheduler to idle. Pending bits survive a port reset, so an interrupted slot is dispatched again.

Top module: `slot_issue_sched`

## Requirements
- R1: A write to the issue register ORs its data into the pending bits. Bit n is slot n. Writing zeros, or writing a bit that is already set, clears nothing.
- R2: A control write stores bit 0 (run) and bit 1 (receive enable). The written values of bit 2 and bit 3 are discarded. Status bit 2 reads back as a copy of bit 1, and status bit 3 reads back as a copy of bit 0.
- R3: No start pulse is issued while the run bit is clear, or while no slot is pending.
- R4: Pending slots are dispatched from the lowest index upward. A slot added while another slot is outstanding is ordered by index when the next choice is made.
- R5: While the engine shows busy or data-request, no new dispatch occurs. The pending slot is retried once both are low.
- R6: If the engine reports done in response to a start, that slot's pending bit clears on the following clock edge.
- R7: If the engine goes busy or raises data-request instead of reporting done, the slot index is held on busy_slot and busy_valid is set. The slot stays pending until busy and data-request are both low. At that point its bit is cleared and busy_valid drops.
- R8: Only one slot is outstanding to the engine at a time. No further start pulse is issued until the current slot has completed.
- R9: A port reset pulse clears busy_valid and returns the scheduler to idle without clearing pending bits. A slot that was in flight is later dispatched again.
- R10: A start pulse lasts exactly one cycle and carries the slot index on eng_slot.
- R11: After the block reset, the pending bits, the control status, eng_start and busy_valid are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset |
| port_rst | input | 1 | Port reset pulse: drops busy record, scheduler to idle |
| issue_wr | input | 1 | Issue register write strobe |
| issue_wdata | input | NSLOT | Slot mask to OR into pending |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 4 | Control write data (bit0 run, bit1 receive enable) |
| eng_done | input | 1 | Engine finished the started slot at once |
| eng_busy | input | 1 | Engine busy |
| eng_drq | input | 1 | Engine data-request |
| issue_pending | output | NSLOT | Pending slot bits |
| ctl_status | output | 4 | Control readback (bit2 receive running, bit3 list running) |
| eng_start | output | 1 | One-cycle dispatch pulse |
| eng_slot | output | SLOT_W | Index of the dispatched slot |
| busy_valid | output | 1 | A slot is held while the engine is busy |
| busy_slot | output | SLOT_W | Index of the held slot |

## Verification
The hardest situation to reach from the ports is a port reset that lands while a slot is held busy. The slot must then stay pending, and it must be dispatched a second time only after the engine goes idle. The bench gets there with an engine model whose busy phase lasts much longer than the reset pulse. It waits for busy_valid, applies the reset, and then switches the model to immediate completion. The scoreboard expects that slot twice. A second situation is a lower-numbered slot issued while a higher one is held. For this the bench issues slot 3 during slot 7's busy phase and checks that no start pulse appears before slot 7 clears.

// File: rtl/sis_pkg.sv
package sis_pkg;
  typedef enum logic [1:0] {
    SCH_IDLE = 2'd0,
    SCH_WAIT = 2'd1,
    SCH_HOLD = 2'd2
  } sch_state_t;

  localparam int CTL_W    = 4;
  localparam int CB_RUN   = 0;
  localparam int CB_RXEN  = 1;
  localparam int CB_RXRUN = 2;
  localparam int CB_LRUN  = 3;
endpackage

// File: rtl/sis_ctrl_reg.sv
module sis_ctrl_reg
  import sis_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [CTL_W-1:0] wdata,
  output logic [CTL_W-1:0] ctrl_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (wr) begin
      ctrl_q[CB_RUN]   <= wdata[CB_RUN];
      ctrl_q[CB_RXEN]  <= wdata[CB_RXEN];
      ctrl_q[CB_RXRUN] <= wdata[CB_RXEN];
      ctrl_q[CB_LRUN]  <= wdata[CB_RUN];
    end
  end

  // Status bits follow the enables, never the written status bits
  assert_status_mirror_R2: assert property (@(posedge clk) disable iff (rst)
    wr |=> (ctrl_q[CB_LRUN] == $past(wdata[CB_RUN])) &&
           (ctrl_q[CB_RXRUN] == $past(wdata[CB_RXEN])));

  assert_ctrl_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !wr |=> $stable(ctrl_q));
endmodule

// File: rtl/sis_issue_reg.sv
module sis_issue_reg #(
  parameter int NSLOT = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_en,
  input  logic [NSLOT-1:0] set_mask,
  input  logic [NSLOT-1:0] clr_mask,
  output logic [NSLOT-1:0] pending
);
  logic [NSLOT-1:0] set_eff;

  assign set_eff = set_en ? set_mask : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= '0;
    end else begin
      pending <= (pending & ~clr_mask) | set_eff;
    end
  end

  assert_or_accumulate_R1: assert property (@(posedge clk) disable iff (rst)
    set_en |=> ((pending & $past(set_mask)) == $past(set_mask)));

  assert_clear_only_on_completion_R6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(pending) & ~pending & ~$past(clr_mask)) == '0));
endmodule

// File: rtl/sis_prio_pick.sv
module sis_prio_pick #(
  parameter int NSLOT  = 32,
  parameter int SLOT_W = 5
) (
  input  logic [NSLOT-1:0]  req,
  output logic              any,
  output logic [SLOT_W-1:0] idx
);
  logic [NSLOT-1:0] lowest_oh;

  // Isolate the lowest set bit, then encode it
  assign lowest_oh = req & (~req + {{(NSLOT-1){1'b0}}, 1'b1});
  assign any       = |req;

  always_comb begin
    idx = '0;
    for (int i = 0; i < NSLOT; i++) begin
      if (lowest_oh[i]) idx = SLOT_W'(i);
    end
  end
endmodule

// File: rtl/sis_dispatch.sv
module sis_dispatch
  import sis_pkg::*;
#(
  parameter int NSLOT  = 32,
  parameter int SLOT_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              port_rst,
  input  logic              run,
  input  logic [NSLOT-1:0]  pending,
  input  logic              pick_any,
  input  logic [SLOT_W-1:0] pick_idx,
  input  logic              eng_done,
  input  logic              eng_busy,
  input  logic              eng_drq,
  output logic              eng_start,
  output logic [SLOT_W-1:0] eng_slot,
  output logic              busy_valid,
  output logic [SLOT_W-1:0] busy_slot,
  output logic [NSLOT-1:0]  clr_mask
);
  localparam logic [NSLOT-1:0] ONE = {{(NSLOT-1){1'b0}}, 1'b1};

  sch_state_t state;
  logic       eng_active;

  assign eng_active = eng_busy | eng_drq;

  always_comb begin
    clr_mask = '0;
    if (!port_rst) begin
      if (state == SCH_WAIT && eng_done)
        clr_mask = ONE << eng_slot;
      else if (state == SCH_HOLD && !eng_active)
        clr_mask = ONE << busy_slot;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= SCH_IDLE;
      eng_start  <= 1'b0;
      eng_slot   <= '0;
      busy_valid <= 1'b0;
      busy_slot  <= '0;
    end else if (port_rst) begin
      state      <= SCH_IDLE;
      eng_start  <= 1'b0;
      busy_valid <= 1'b0;
    end else begin
      eng_start <= 1'b0;
      case (state)
        SCH_IDLE: begin
          if (run && pick_any && !eng_active) begin
            eng_start <= 1'b1;
            eng_slot  <= pick_idx;
            state     <= SCH_WAIT;
          end
        end
        SCH_WAIT: begin
          if (eng_done) begin
            state <= SCH_IDLE;
          end else if (eng_active) begin
            busy_slot  <= eng_slot;
            busy_valid <= 1'b1;
            state      <= SCH_HOLD;
          end
        end
        SCH_HOLD: begin
          if (!eng_active) begin
            busy_valid <= 1'b0;
            state      <= SCH_IDLE;
          end
        end
        default: state <= SCH_IDLE;
      endcase
    end
  end

  assert_start_needs_run_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(eng_start) |-> $past(run) && ($past(pending) != '0));

  assert_lowest_first_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(eng_start) |-> (($past(pending) & ((ONE << eng_slot) - ONE)) == '0));

  assert_defer_when_busy_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(eng_start) |-> !$past(eng_busy) && !$past(eng_drq));

  assert_held_stays_pending_R7: assert property (@(posedge clk) disable iff (rst)
    busy_valid |-> pending[busy_slot]);

  assert_single_outstanding_R8: assert property (@(posedge clk) disable iff (rst)
    busy_valid |-> !eng_start);

  assert_port_reset_drops_R9: assert property (@(posedge clk) disable iff (rst)
    port_rst |=> !busy_valid && !eng_start);

  assert_one_cycle_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    eng_start |=> !eng_start);
endmodule

// File: rtl/slot_issue_sched.sv
module slot_issue_sched
  import sis_pkg::*;
#(
  parameter int NSLOT  = 32,
  parameter int SLOT_W = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              port_rst,
  input  logic              issue_wr,
  input  logic [NSLOT-1:0]  issue_wdata,
  input  logic              ctl_wr,
  input  logic [3:0]        ctl_wdata,
  input  logic              eng_done,
  input  logic              eng_busy,
  input  logic              eng_drq,
  output logic [NSLOT-1:0]  issue_pending,
  output logic [3:0]        ctl_status,
  output logic              eng_start,
  output logic [SLOT_W-1:0] eng_slot,
  output logic              busy_valid,
  output logic [SLOT_W-1:0] busy_slot
);
  logic [NSLOT-1:0]  clr_mask;
  logic              pick_any;
  logic [SLOT_W-1:0] pick_idx;

  sis_ctrl_reg u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .wr     (ctl_wr),
    .wdata  (ctl_wdata),
    .ctrl_q (ctl_status)
  );

  sis_issue_reg #(.NSLOT(NSLOT)) u_issue (
    .clk      (clk),
    .rst      (rst),
    .set_en   (issue_wr),
    .set_mask (issue_wdata),
    .clr_mask (clr_mask),
    .pending  (issue_pending)
  );

  sis_prio_pick #(.NSLOT(NSLOT), .SLOT_W(SLOT_W)) u_pick (
    .req (issue_pending),
    .any (pick_any),
    .idx (pick_idx)
  );

  sis_dispatch #(.NSLOT(NSLOT), .SLOT_W(SLOT_W)) u_disp (
    .clk        (clk),
    .rst        (rst),
    .port_rst   (port_rst),
    .run        (ctl_status[CB_RUN]),
    .pending    (issue_pending),
    .pick_any   (pick_any),
    .pick_idx   (pick_idx),
    .eng_done   (eng_done),
    .eng_busy   (eng_busy),
    .eng_drq    (eng_drq),
    .eng_start  (eng_start),
    .eng_slot   (eng_slot),
    .busy_valid (busy_valid),
    .busy_slot  (busy_slot),
    .clr_mask   (clr_mask)
  );
endmodule

// File: tb/sim_slot_issue_sched.sv
module sim_slot_issue_sched;
  localparam int CLK_PERIOD = 10;
  localparam int NSLOT = 32;
  localparam int SLOT_W = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic port_rst = 1'b0;
  logic issue_wr = 1'b0;
  logic [NSLOT-1:0] issue_wdata = '0;
  logic ctl_wr = 1'b0;
  logic [3:0] ctl_wdata = '0;
  logic eng_done = 1'b0;
  logic busy_m = 1'b0, drq_m = 1'b0, ext_busy = 1'b0;
  logic eng_busy, eng_drq;
  logic [NSLOT-1:0] issue_pending;
  logic [3:0] ctl_status;
  logic eng_start;
  logic [SLOT_W-1:0] eng_slot;
  logic busy_valid;
  logic [SLOT_W-1:0] busy_slot;

  assign eng_busy = busy_m | ext_busy;
  assign eng_drq  = drq_m;

  always #(CLK_PERIOD/2) clk = ~clk;

  slot_issue_sched #(.NSLOT(NSLOT)) u0 (
    .clk(clk), .rst(rst), .port_rst(port_rst),
    .issue_wr(issue_wr), .issue_wdata(issue_wdata),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .eng_done(eng_done), .eng_busy(eng_busy), .eng_drq(eng_drq),
    .issue_pending(issue_pending), .ctl_status(ctl_status),
    .eng_start(eng_start), .eng_slot(eng_slot),
    .busy_valid(busy_valid), .busy_slot(busy_slot)
  );

  int total = 0;
  int bad = 0;
  int exp_q[$];
  int mode = 0;      // 0: done at once, 1: go busy/drq
  bit use_drq = 1'b0;
  int hold_len = 4;
  int hold_cnt = 0;
  bit prev_start = 1'b0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Engine model: reacts at the falling edge to a start pulse
  always @(negedge clk) begin
    eng_done = 1'b0;
    if (hold_cnt > 0) begin
      hold_cnt--;
      if (hold_cnt == 0) begin
        busy_m = 1'b0;
        drq_m  = 1'b0;
      end
    end
    if (!rst && eng_start) begin
      if (mode == 0) eng_done = 1'b1;
      else begin
        if (use_drq) drq_m = 1'b1; else busy_m = 1'b1;
        hold_cnt = hold_len;
      end
    end
  end

  // Scoreboard monitor: each start pulse pops one expected slot
  always @(negedge clk) begin
    if (!rst) begin
      if (eng_start) begin
        chk(!prev_start, "R10", 1, 0);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R3/R8 unexpected start", eng_slot, 0);
        end else begin
          int e;
          e = exp_q.pop_front();
          chk(eng_slot == SLOT_W'(e), "R4/R10 slot order", eng_slot, e);
        end
      end
      prev_start = eng_start;
    end
  end

  task automatic wr_issue(input logic [NSLOT-1:0] v);
    @(negedge clk);
    issue_wr = 1'b1; issue_wdata = v;
    @(negedge clk);
    issue_wr = 1'b0; issue_wdata = '0;
  endtask

  task automatic wr_ctl(input logic [3:0] v);
    @(negedge clk);
    ctl_wr = 1'b1; ctl_wdata = v;
    @(negedge clk);
    ctl_wr = 1'b0; ctl_wdata = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_clear(input logic [NSLOT-1:0] m, input string req);
    for (int i = 0; i < 300; i++) begin
      if ((issue_pending & m) == '0) break;
      @(negedge clk);
    end
    chk((issue_pending & m) == '0, req, issue_pending, issue_pending & ~m);
  endtask

  task automatic wait_busy_valid();
    for (int i = 0; i < 50; i++) begin
      if (busy_valid) break;
      @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    chk(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(3);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk(issue_pending == '0, "R11 pending", issue_pending, 0);
    chk(ctl_status == 4'h0, "R11 status", ctl_status, 0);
    chk(!eng_start && !busy_valid, "R11 start/busy", {eng_start, busy_valid}, 0);

    // R2 written status bits discarded, mirrors follow enables
    wr_ctl(4'b1100);
    chk(ctl_status == 4'b0000, "R2 status ignored", ctl_status, 4'b0000);
    wr_ctl(4'b0010);
    chk(ctl_status == 4'b0110, "R2 rx mirror", ctl_status, 4'b0110);

    // R1 accumulate while not running (R3: no dispatch)
    wr_issue(32'h0000_0005);
    wr_issue(32'h0000_0030);
    chk(issue_pending == 32'h35, "R1 or-accumulate", issue_pending, 32'h35);
    wr_issue(32'h0);
    wr_issue(32'h1);
    idle(4);
    chk(issue_pending == 32'h35, "R1 no clear / R3 no run", issue_pending, 32'h35);

    // R4/R6 run with immediate completion
    exp_q.push_back(0); exp_q.push_back(2); exp_q.push_back(4); exp_q.push_back(5);
    wr_ctl(4'b0011);
    chk(ctl_status == 4'b1111, "R2 list mirror", ctl_status, 4'b1111);
    wait_clear(32'h35, "R6 immediate clear");
    idle(3);
    chk(exp_q.size() == 0, "R4 all dispatched", exp_q.size(), 0);

    // R4 ordering of high and low bits in one write
    exp_q.push_back(1); exp_q.push_back(31);
    wr_issue(32'h8000_0002);
    wait_clear(32'h8000_0002, "R6 clear 1/31");
    idle(2);
    chk(exp_q.size() == 0, "R4 order 1 then 31", exp_q.size(), 0);

    // R7/R8 asynchronous slot, lower slot issued during hold
    mode = 1; use_drq = 1'b0; hold_len = 14;
    exp_q.push_back(7);
    wr_issue(32'h80);
    wait_busy_valid();
    chk(busy_valid && busy_slot == 7, "R7 record", busy_slot, 7);
    chk(issue_pending[7], "R7 stays pending", issue_pending, 32'h80);
    mode = 0;
    exp_q.push_back(3);
    wr_issue(32'h8);
    idle(2);
    chk(exp_q.size() == 1 && issue_pending[7] && issue_pending[3], "R8 one outstanding",
        exp_q.size(), 1);
    wait_clear(32'h88, "R7 clear after busy");
    idle(2);
    chk(!busy_valid, "R7 record dropped", busy_valid, 0);
    chk(exp_q.size() == 0, "R4 7 then 3", exp_q.size(), 0);

    // R7 data-request path
    mode = 1; use_drq = 1'b1; hold_len = 5;
    exp_q.push_back(10);
    wr_issue(32'h400);
    wait_busy_valid();
    chk(busy_valid && busy_slot == 10, "R7 drq record", busy_slot, 10);
    mode = 0; use_drq = 1'b0;
    wait_clear(32'h400, "R7 drq clear");
    idle(2);

    // R5 engine busy blocks dispatch
    ext_busy = 1'b1;
    exp_q.push_back(9);
    wr_issue(32'h200);
    idle(6);
    chk(issue_pending[9] && exp_q.size() == 1, "R5 deferred", issue_pending, 32'h200);
    ext_busy = 1'b0;
    wait_clear(32'h200, "R5 retried");
    idle(2);

    // R9 port reset while a slot is held
    mode = 1; hold_len = 40;
    exp_q.push_back(12); exp_q.push_back(12);
    wr_issue(32'h1000);
    wait_busy_valid();
    chk(busy_valid, "R9 held before reset", busy_valid, 1);
    mode = 0;
    port_rst = 1'b1;
    @(negedge clk);
    port_rst = 1'b0;
    chk(!busy_valid && issue_pending[12], "R9 record dropped, pending kept",
        {busy_valid, issue_pending[12]}, 1);
    wait_clear(32'h1000, "R9 redispatch");
    idle(2);
    chk(exp_q.size() == 0, "R9 dispatched twice", exp_q.size(), 0);

    // R3 run cleared stops dispatch
    wr_ctl(4'b0000);
    wr_issue(32'h0010_0000);
    idle(5);
    chk(issue_pending == 32'h0010_0000, "R3 stopped", issue_pending, 32'h0010_0000);
    exp_q.push_back(20);
    wr_ctl(4'b0001);
    wait_clear(32'h0010_0000, "R3 resumed");
    idle(3);
    chk(exp_q.size() == 0, "R4 scoreboard empty", exp_q.size(), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule